// File: doc/BRIEF.md
# Glitch-Filtered Command Decoder for a Byte-Wide Memory Expander

This block sits between a host that owns three control lines and an 8-bit shared port, and an external byte-wide memory addressed by a wide pointer. The host selects one of seven commands by driving a 3-bit code on the control lines; the all-ones code means "do nothing". Four commands move a byte between the port and memory and then step the pointer up or down. Three commands load one byte of the pointer from the port, so any address can be set up byte by byte.

The host cannot switch its three lines at exactly the same instant, so the block never decodes a code the moment it appears. The lines pass through a synchroniser, and a code that leaves idle must stay unchanged for a fixed number of clocks. Only then does a single enable pulse of fixed width gate the decode. The code is captured once, at the start of that pulse. After the pulse the block ignores the lines until they go back to all-ones. A change of code during the waiting period restarts the wait, so a code the host only passes through on its way to another never takes effect.

The outputs are the memory address, a write strobe, a read strobe and the port direction. The pointer is 24 bits by default. A two-byte build gives a 64 KB space.

Top module: `cmdFilterTop`

## Requirements
- R1: After reset the address is 0 and the write strobe, the read strobe and the port direction are low. While the control code (bit 2 = C, bit 0 = A) stays at 3'b111 no strobe is produced and the address does not change.
- R2: Code 3'b100 loads the port byte into address bits 7:0, 3'b101 into bits 15:8 and 3'b110 into bits 23:16. The other address bits are left unchanged, and no memory strobe is raised.
- R3: Code 3'b000 writes and then adds one to the address; 3'b001 reads and then adds one; 3'b010 writes and then subtracts one; 3'b011 reads and then subtracts one. During the strobe the address shows the value from before the step.
- R4: A write command raises the write strobe, and a read command raises both the read strobe and the port direction (1 = memory drives the port toward the host), each for exactly PULSE_CYC consecutive clocks. The write and read strobes are never high together.
- R5: After the synchroniser, a code other than 3'b111 must be seen unchanged on DELAY_CYC+1 consecutive clocks before its pulse starts. A code held for DELAY_CYC clocks or fewer causes no strobe and no address change.
- R6: If the code changes to another non-idle value during the wait, the wait starts again from zero and only the final code is carried out.
- R7: Each departure from 3'b111 produces at most one command, however long the code is held. A new command needs the lines to return to 3'b111 first.
- R8: Stepping the address wraps modulo 2^(8*ADDR_BYTES): adding one to all-ones gives 0, and subtracting one from 0 gives all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlIn | input | 3 | Host command lines, 3'b111 = idle |
| portIn | input | 8 | Byte on the shared port, used by pointer loads |
| memAddr | output | 8*ADDR_BYTES | Memory address pointer |
| memWe | output | 1 | Memory write strobe, active high |
| memOe | output | 1 | Memory read strobe, active high |
| portToHost | output | 1 | Port direction, 1 while memory drives the port |

## Verification
The hardest case to reach from the ports is a code the host passes through while its lines settle: it leaves idle but must never fire, and it must also not delay or cancel the code the host actually meant. The stimulus holds one code for a few clocks and then switches straight to a different code without passing through idle. It also holds codes for exactly the delay length, one clock short of firing. Random commands, mixed with directed loads of all-ones followed by up and down steps, cover the wrap-around. Strobe widths and the address shown during each strobe are counted at the ports.

// File: rtl/cmdFilterPkg.sv
package cmdFilterPkg;

  typedef enum logic [2:0] {
    CMD_WR_UP  = 3'b000,
    CMD_RD_UP  = 3'b001,
    CMD_WR_DN  = 3'b010,
    CMD_RD_DN  = 3'b011,
    CMD_LD_LO  = 3'b100,
    CMD_LD_MID = 3'b101,
    CMD_LD_HI  = 3'b110,
    CMD_IDLE   = 3'b111
  } cmd_e;

  // control -> datapath strobe bundle
  typedef struct packed {
    logic       active;   // enable pulse in progress
    logic       wr;       // memory write command
    logic       rd;       // memory read command
    logic       down;     // step direction: 1 = decrement
    logic       commit;   // last pulse cycle: update the pointer
    logic [2:0] loadSel;  // one-hot pointer byte lane to load
  } strobe_t;

  function automatic strobe_t decodeCmd(input logic [2:0] code);
    strobe_t s;
    s = '0;
    unique case (cmd_e'(code))
      CMD_WR_UP:  s.wr = 1'b1;
      CMD_RD_UP:  s.rd = 1'b1;
      CMD_WR_DN:  begin s.wr = 1'b1; s.down = 1'b1; end
      CMD_RD_DN:  begin s.rd = 1'b1; s.down = 1'b1; end
      CMD_LD_LO:  s.loadSel = 3'b001;
      CMD_LD_MID: s.loadSel = 3'b010;
      CMD_LD_HI:  s.loadSel = 3'b100;
      default:    s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cmdSeq.sv
module cmdSeq
  import cmdFilterPkg::*;
#(
  parameter int DELAY_CYC   = 4,
  parameter int PULSE_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ctrlIn,
  output strobe_t    strb
);

  localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_PULSE, ST_HOLD} state_e;

  // synchroniser chain, reset to the idle code
  logic [2:0] syncQ [SYNC_STAGES];
  logic [2:0] syncd;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= CMD_IDLE;
          else       syncQ[0] <= ctrlIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= CMD_IDLE;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  assign syncd = syncQ[SYNC_STAGES-1];

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       heldCode;
  strobe_t          cmdQ;
  logic             isIdleCode;

  assign isIdleCode = (syncd == CMD_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      heldCode <= CMD_IDLE;
      cmdQ     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!isIdleCode) begin
            state    <= ST_DELAY;
            heldCode <= syncd;
            cnt      <= '0;
          end
        end
        ST_DELAY: begin
          if (isIdleCode) begin
            state <= ST_IDLE;
          end else if (syncd != heldCode) begin
            heldCode <= syncd;       // restart the qualification window
            cnt      <= '0;
          end else if (cnt == DELAY_LAST) begin
            state <= ST_PULSE;
            cnt   <= '0;
            cmdQ  <= decodeCmd(heldCode);  // single sample at pulse start
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt == PULSE_LAST) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (isIdleCode) state <= ST_IDLE;
        end
      endcase
    end
  end

  logic pulseOn;
  assign pulseOn = (state == ST_PULSE);

  always_comb begin
    strb         = '0;
    strb.wr      = cmdQ.wr;
    strb.rd      = cmdQ.rd;
    strb.down    = cmdQ.down;
    strb.loadSel = cmdQ.loadSel;
    strb.active  = pulseOn;
    strb.commit  = pulseOn && (cnt == PULSE_LAST);
  end

  AST_PULSE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.active) |-> $past(state) == ST_DELAY); // R5

  AST_RESTART_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELAY && !isIdleCode && syncd != heldCode) |=> (state == ST_DELAY && cnt == '0)); // R6

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> !strb.active); // R7

  AST_PULSE_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.commit) |=> strb.active); // R4

endmodule

// File: rtl/ptrPath.sv
module ptrPath
  import cmdFilterPkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [7:0]              portIn,
  output logic [8*ADDR_BYTES-1:0] memAddr
);

  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] loaded;
  logic [ADDR_W-1:0] stepped;

  generate
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
      assign loaded[8*i +: 8] = strb.loadSel[i] ? portIn : ptrQ[8*i +: 8];
    end
  endgenerate

  assign stepped = strb.down ? (ptrQ - 1'b1) : (ptrQ + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strb.commit) begin
      if (strb.wr || strb.rd) ptrQ <= stepped;
      else                    ptrQ <= loaded;
    end
  end

  assign memAddr = ptrQ;

  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(memAddr)); // R3

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && (strb.wr || strb.rd) && !strb.down && memAddr == '1) |=> memAddr == '0); // R8

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && (strb.wr || strb.rd) && strb.down && memAddr == '0) |=> memAddr == '1); // R8

endmodule

// File: rtl/cmdFilterTop.sv
module cmdFilterTop
  import cmdFilterPkg::*;
#(
  parameter int DELAY_CYC   = 4,
  parameter int PULSE_CYC   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BYTES  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              ctrlIn,
  input  logic [7:0]              portIn,
  output logic [8*ADDR_BYTES-1:0] memAddr,
  output logic                    memWe,
  output logic                    memOe,
  output logic                    portToHost
);

  strobe_t strb;

  cmdSeq #(
    .DELAY_CYC  (DELAY_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk   (clk),
    .rstN  (rstN),
    .ctrlIn(ctrlIn),
    .strb  (strb)
  );

  ptrPath #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .portIn (portIn),
    .memAddr(memAddr)
  );

  assign memWe      = strb.active && strb.wr;
  assign memOe      = strb.active && strb.rd;
  assign portToHost = strb.active && strb.rd;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memOe)); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((memWe || memOe) && $past(memWe || memOe)) |-> $stable(memAddr)); // R3

endmodule

// File: tb/cmdFilterTop_bench.sv
module cmdFilterTop_bench;

  localparam int DELAY_CYC   = 4;
  localparam int PULSE_CYC   = 3;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_BYTES  = 3;
  localparam int ADDR_W      = 8 * ADDR_BYTES;
  localparam int HOLD        = SYNC_STAGES + DELAY_CYC + PULSE_CYC + 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        ctrlIn = 3'b111;
  logic [7:0]        portIn = 8'h00;
  logic [ADDR_W-1:0] memAddr;
  logic              memWe, memOe, portToHost;

  int checks = 0;
  int errors = 0;
  int weCnt = 0, oeCnt = 0, dirCnt = 0, badAddr = 0;
  logic [ADDR_W-1:0] expPtr = '0;
  logic [ADDR_W-1:0] preAddr = '0;
  bit done = 0;

  always #5 clk = ~clk;

  cmdFilterTop #(
    .DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC),
    .SYNC_STAGES(SYNC_STAGES), .ADDR_BYTES(ADDR_BYTES)
  ) u_cmdFilterTop (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlIn), .portIn(portIn),
    .memAddr(memAddr), .memWe(memWe), .memOe(memOe), .portToHost(portToHost)
  );

  always @(negedge clk) begin
    if (memWe) weCnt++;
    if (memOe) oeCnt++;
    if (portToHost) dirCnt++;
    if ((memWe || memOe) && memAddr != preAddr) badAddr++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] model(input logic [2:0] code,
      input logic [ADDR_W-1:0] p, input logic [7:0] d);
    logic [ADDR_W-1:0] n;
    n = p;
    case (code)
      3'b000, 3'b001: n = p + 1'b1;
      3'b010, 3'b011: n = p - 1'b1;
      3'b100: n[7:0] = d;
      3'b101: n[15:8] = d;
      3'b110: n[23:16] = d;
      default: n = p;
    endcase
    return n;
  endfunction

  function automatic int expWe(input logic [2:0] c);
    return (c == 3'b000 || c == 3'b010) ? PULSE_CYC : 0;
  endfunction

  function automatic int expOe(input logic [2:0] c);
    return (c == 3'b001 || c == 3'b011) ? PULSE_CYC : 0;
  endfunction

  task automatic clearCounts();
    preAddr = expPtr;
    weCnt = 0; oeCnt = 0; dirCnt = 0; badAddr = 0;
  endtask

  task automatic checkAfter(input logic [2:0] code, input string req);
    check(memAddr == expPtr, req, "address", memAddr, expPtr);
    check(weCnt == expWe(code), req, "write strobe cycles", weCnt, expWe(code));
    check(oeCnt == expOe(code), req, "read strobe cycles", oeCnt, expOe(code));
    check(dirCnt == expOe(code), req, "port direction cycles", dirCnt, expOe(code));
    check(badAddr == 0, req, "address moved during strobe", badAddr, 0);
  endtask

  // full command: hold code, return to idle, settle
  task automatic runCmd(input logic [2:0] code, input logic [7:0] data,
                        input int hold, input string req);
    clearCounts();
    @(negedge clk);
    ctrlIn = code; portIn = data;
    repeat (hold) @(negedge clk);
    ctrlIn = 3'b111;
    repeat (SYNC_STAGES + 4) @(negedge clk);
    expPtr = model(code, preAddr, data);
    checkAfter(code, req);
  endtask

  // short excursion from idle that must not fire
  task automatic runGlitch(input logic [2:0] code, input int cyc, input string req);
    clearCounts();
    @(negedge clk);
    ctrlIn = code; portIn = 8'hA5;
    repeat (cyc) @(negedge clk);
    ctrlIn = 3'b111;
    repeat (SYNC_STAGES + DELAY_CYC + PULSE_CYC + 4) @(negedge clk);
    checkAfter(3'b111, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(memAddr == '0, "R1", "reset address", memAddr, 0);
    check(!memWe && !memOe && !portToHost, "R1", "reset strobes",
          {memWe, memOe, portToHost}, 0);
    clearCounts();
    repeat (20) @(negedge clk);
    checkAfter(3'b111, "R1");

    // R2: load each byte lane
    runCmd(3'b100, 8'h34, HOLD, "R2");
    runCmd(3'b101, 8'h12, HOLD, "R2");
    runCmd(3'b110, 8'hAB, HOLD, "R2");
    check(memAddr == 24'hAB1234, "R2", "assembled pointer", memAddr, 24'hAB1234);

    // R3 / R4: all four transfer commands
    runCmd(3'b000, 8'h00, HOLD, "R3");
    runCmd(3'b001, 8'h00, HOLD, "R3");
    runCmd(3'b010, 8'h00, HOLD, "R4");
    runCmd(3'b011, 8'h00, HOLD, "R4");

    // R5: codes held up to the delay length never fire
    runGlitch(3'b000, 1, "R5");
    runGlitch(3'b001, DELAY_CYC, "R5");
    runGlitch(3'b100, DELAY_CYC, "R5");
    // one clock longer fires (pulse runs even after lines return to idle)
    runCmd(3'b000, 8'h00, DELAY_CYC + 1, "R5");

    // R6: pass through a transfer code on the way to a load code
    clearCounts();
    @(negedge clk);
    ctrlIn = 3'b000; portIn = 8'h5C;
    repeat (3) @(negedge clk);
    ctrlIn = 3'b100;
    repeat (HOLD) @(negedge clk);
    ctrlIn = 3'b111;
    repeat (SYNC_STAGES + 4) @(negedge clk);
    expPtr = model(3'b100, preAddr, 8'h5C);
    checkAfter(3'b100, "R6");

    // R7: long hold fires once only
    runCmd(3'b001, 8'h00, 60, "R7");
    runCmd(3'b010, 8'h00, 45, "R7");

    // R8: wrap in both directions
    runCmd(3'b100, 8'hFF, HOLD, "R8");
    runCmd(3'b101, 8'hFF, HOLD, "R8");
    runCmd(3'b110, 8'hFF, HOLD, "R8");
    runCmd(3'b000, 8'h00, HOLD, "R8");
    check(memAddr == '0, "R8", "wrap up to zero", memAddr, 0);
    runCmd(3'b011, 8'h00, HOLD, "R8");
    check(memAddr == '1, "R8", "wrap down to all-ones", memAddr, 24'hFFFFFF);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] c;
      logic [7:0] d;
      c = 3'($urandom % 7);
      d = 8'($urandom);
      if (($urandom % 5) == 0) runGlitch(c, 1 + int'($urandom % DELAY_CYC), "R5");
      else runCmd(c, d, HOLD + int'($urandom % 6), (c[2]) ? "R2" : "R3");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule